// File: doc/BRIEF.md
# Command/Data Parallel Bus Master

This block is the host side of an 8-bit peripheral bus on which one address line picks between a command register (line high) and a data port (line low). Active-low read and write strobes qualify each access. The peripheral raises an active-low interrupt. A user-side valid/ready request carries one transaction. Every transaction starts with a command byte written in command phase. A burst of zero to eight data-phase bytes follows, all reads or all writes.

The controller times each access in system clock cycles. Three parameters give the strobe pulse width, the write hold time and the idle recovery gap in nanoseconds. Each one is turned into a cycle count rounded upward. Read bytes come back one per pulse of a valid strobe, in bus order. A single-cycle done pulse closes the transaction, and the block then accepts the next request. The interrupt input is synchronised and presented as an active-high level.

Top module: `pbus_master`

## Requirements
- R1: After reset `req_ready` is 1, both strobes are high, `bus_oe` is 0, and `rd_valid`, `done` and `irq` are 0.
- R2: The first access of a transaction writes `req_cmd` with `bus_a0` = 1. Every later access of the same transaction uses `bus_a0` = 0, and `bus_a0` does not change while a strobe is low.
- R3: On a write access `bus_oe` is 1 and `bus_dout` already holds the byte at least one cycle before `bus_wr_n` falls. Both stay unchanged while `bus_wr_n` is low.
- R4: Every strobe stays low for at least STROBE_CYC = ceil(STROBE_NS*1000/CLK_PS) cycles.
- R5: After `bus_wr_n` rises, `bus_oe` stays 1 for at least HOLD_CYC = ceil(HOLD_NS*1000/CLK_PS) cycles before it falls.
- R6: On a read access `bus_oe` is 0 while `bus_rd_n` is low. `bus_din` is sampled in the last low cycle. Each sampled byte appears once on `rd_data` with `rd_valid` high, in access order.
- R7: Before every access the bus is quiet (both strobes high, `bus_oe` 0) for at least GAP_CYC = ceil(GAP_NS*1000/CLK_PS) consecutive cycles.
- R8: A transaction makes exactly 1 + L data accesses, where L is `req_len` limited to MAX_BYTES. A write transaction sends byte i from `req_wdata[8i+7:8i]`, i = 0 first. A transaction with `req_rd` = 1 reads instead.
- R9: `done` is high for exactly one cycle after the last access of a transaction, and `req_ready` is 1 from that cycle.
- R10: While a transaction is in progress `req_ready` is 0. A `req_valid` raised and dropped during that time starts no access.
- R11: `irq` equals the inverse of `intr_n` delayed by two clock edges.
- R12: `bus_rd_n` and `bus_wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid is high |
| req_cmd | input | 8 | Command byte |
| req_rd | input | 1 | 1 = data phase reads, 0 = data phase writes |
| req_len | input | 4 | Number of data bytes, limited to MAX_BYTES |
| req_wdata | input | 64 | Write bytes, byte i in bits [8i+7:8i] |
| rd_valid | output | 1 | One-cycle strobe for a returned read byte |
| rd_data | output | 8 | Returned read byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| bus_a0 | output | 1 | Phase select, 1 = command, 0 = data |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_oe | output | 1 | Data bus drive enable |
| bus_dout | output | 8 | Data bus value driven when enabled |
| bus_din | input | 8 | Data bus value from the peripheral |
| intr_n | input | 1 | Active-low interrupt from the peripheral |
| irq | output | 1 | Synchronised active-high interrupt level |

## Verification
The hardest situation to provoke is a request that shows up mid-transaction and then goes away before the controller is idle again. A correct design must let that request leave no trace on the bus. The bench starts a write burst and raises `req_valid` with a different command deep inside the burst. It drops the request before the burst ends, then counts the accesses on the bus after completion to show nothing extra was issued. The bus model changes `bus_din` to a fresh random byte only while the read strobe is low and shows the inverted byte otherwise, so a capture at the wrong cycle returns a wrong value. Random read and write bursts of every length, plus a length above the limit, cover the rest.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } seq_state_t;

  // Minimum time in ns to a whole number of clock cycles, never shorter.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/pbus_rst_sync.sv
module pbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sync_n = pipe_q[1];
endmodule

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pbus_timer.sv
module pbus_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int DW         = 8,
  parameter int MAXB       = 8,
  parameter int LENW       = 4,
  parameter int CW         = 8,
  parameter int GAP_CYC    = 250,
  parameter int STROBE_CYC = 10,
  parameter int HOLD_CYC   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [DW-1:0]        req_cmd,
  input  logic                 req_rd,
  input  logic [LENW-1:0]      req_len,
  input  logic [MAXB*DW-1:0]   req_wdata,
  output logic                 tmr_load,
  output logic [CW-1:0]        tmr_val,
  input  logic                 tmr_expired,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data,
  output logic                 done,
  output logic                 bus_a0,
  output logic                 bus_rd_n,
  output logic                 bus_wr_n,
  output logic                 bus_oe,
  output logic [DW-1:0]        bus_dout,
  input  logic [DW-1:0]        bus_din
);
  localparam int IW = (MAXB > 1) ? $clog2(MAXB) : 1;
  localparam logic [LENW-1:0] MAX_LEN = LENW'(MAXB);
  localparam logic [CW-1:0] GAP_LD    = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] STROBE_LD = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CYC - 1);

  seq_state_t state_q, state_d;
  logic [LENW-1:0] idx_q, idx_d;
  logic [LENW-1:0] len_q, len_lim;
  logic            rd_q;
  logic [DW-1:0]   cmd_q;
  logic [MAXB-1:0][DW-1:0] wdata_q;
  logic            a0_q;
  logic [DW-1:0]   dout_q;
  logic [DW-1:0]   rdata_q;
  logic            rvalid_q, rvalid_d;
  logic            done_q, done_d;

  logic            accept;
  logic            ld_byte;
  logic            cap;
  logic            data_rd;
  logic [LENW-1:0] widx;
  logic [DW-1:0]   sel_byte;

  assign len_lim = (req_len > MAX_LEN) ? MAX_LEN : req_len;
  assign data_rd = rd_q && (idx_q != '0);
  assign widx    = idx_q - 1'b1;
  assign sel_byte = (idx_q == '0) ? cmd_q : wdata_q[widx[IW-1:0]];

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    ld_byte  = 1'b0;
    cap      = 1'b0;
    rvalid_d = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          idx_d    = '0;
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
        end
      end
      ST_GAP: begin
        if (tmr_expired) begin
          ld_byte = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = STROBE_LD;
      end
      ST_STROBE: begin
        if (tmr_expired) begin
          cap      = data_rd;
          rvalid_d = data_rd;
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LD;
        end
      end
      ST_HOLD: begin
        if (tmr_expired) begin
          if (idx_q == len_q) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            idx_d    = idx_q + 1'b1;
            state_d  = ST_GAP;
            tmr_load = 1'b1;
            tmr_val  = GAP_LD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      len_q    <= '0;
      rd_q     <= 1'b0;
      cmd_q    <= '0;
      wdata_q  <= '0;
      a0_q     <= 1'b0;
      dout_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      rvalid_q <= rvalid_d;
      done_q   <= done_d;
      if (accept) begin
        len_q   <= len_lim;
        rd_q    <= req_rd;
        cmd_q   <= req_cmd;
        wdata_q <= req_wdata;
      end
      if (ld_byte) begin
        a0_q   <= (idx_q == '0);
        dout_q <= sel_byte;
      end
      if (cap) rdata_q <= bus_din;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign bus_a0    = a0_q;
  assign bus_dout  = dout_q;
  assign bus_rd_n  = !((state_q == ST_STROBE) && data_rd);
  assign bus_wr_n  = !((state_q == ST_STROBE) && !data_rd);
  assign bus_oe    = ((state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                      (state_q == ST_HOLD)) && !data_rd;
  assign rd_valid  = rvalid_q;
  assign rd_data   = rdata_q;
  assign done      = done_q;
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 8,
  parameter int CLK_PS    = 4000,
  parameter int STROBE_NS = 40,
  parameter int HOLD_NS   = 40,
  parameter int GAP_NS    = 1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [DATA_W-1:0]             req_cmd,
  input  logic                          req_rd,
  input  logic [$clog2(MAX_BYTES+1)-1:0] req_len,
  input  logic [MAX_BYTES*DATA_W-1:0]   req_wdata,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          done,
  output logic                          bus_a0,
  output logic                          bus_rd_n,
  output logic                          bus_wr_n,
  output logic                          bus_oe,
  output logic [DATA_W-1:0]             bus_dout,
  input  logic [DATA_W-1:0]             bus_din,
  input  logic                          intr_n,
  output logic                          irq
);
  localparam int LEN_W      = $clog2(MAX_BYTES + 1);
  localparam int STROBE_CYC = ns_to_cyc(STROBE_NS, CLK_PS);
  localparam int HOLD_CYC   = ns_to_cyc(HOLD_NS, CLK_PS);
  localparam int GAP_CYC    = ns_to_cyc(GAP_NS, CLK_PS);
  localparam int MAX_CYC    = (GAP_CYC > STROBE_CYC) ?
                              ((GAP_CYC > HOLD_CYC) ? GAP_CYC : HOLD_CYC) :
                              ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic             rst_int_n;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             intr_sync;

  pbus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pbus_sync #(.W(1)) u_irq_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (~intr_n),
    .q     (intr_sync)
  );
  assign irq = intr_sync;

  pbus_timer #(.CW(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pbus_seq #(
    .DW         (DATA_W),
    .MAXB       (MAX_BYTES),
    .LENW       (LEN_W),
    .CW         (CNT_W),
    .GAP_CYC    (GAP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_cmd     (req_cmd),
    .req_rd      (req_rd),
    .req_len     (req_len),
    .req_wdata   (req_wdata),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .tmr_expired (tmr_expired),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .done        (done),
    .bus_a0      (bus_a0),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_oe      (bus_oe),
    .bus_dout    (bus_dout),
    .bus_din     (bus_din)
  );
endmodule

// File: rtl/pbus_chk.sv
module pbus_chk #(
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 10,
  parameter int HOLD_CYC   = 10,
  parameter int GAP_CYC    = 250
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              bus_a0,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_dout
);
  logic        strobe_any;
  logic        quiet;
  logic [15:0] low_run_q;
  logic [15:0] quiet_run_q;
  logic [15:0] hold_run_q;

  assign strobe_any = !bus_rd_n || !bus_wr_n;
  assign quiet      = bus_rd_n && bus_wr_n && !bus_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q   <= '0;
      quiet_run_q <= '0;
      hold_run_q  <= '0;
    end else begin
      low_run_q   <= strobe_any ? ((low_run_q == 16'hffff) ? low_run_q : low_run_q + 1'b1) : '0;
      quiet_run_q <= quiet ? ((quiet_run_q == 16'hffff) ? quiet_run_q : quiet_run_q + 1'b1) : '0;
      hold_run_q  <= (bus_oe && bus_wr_n) ? ((hold_run_q == 16'hffff) ? hold_run_q : hold_run_q + 1'b1) : '0;
    end
  end

  AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R12
  AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_oe); // R3
  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe); // R6
  AST_PHASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |=> (!strobe_any || ($stable(bus_a0) && $stable(bus_dout)))); // R2
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_any) |-> (low_run_q >= 16'(STROBE_CYC))); // R4
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> (hold_run_q >= 16'(HOLD_CYC))); // R5
  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(quiet) |-> (quiet_run_q >= 16'(GAP_CYC))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> quiet); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R9
endmodule

bind pbus_master pbus_chk #(
  .DATA_W     (DATA_W),
  .STROBE_CYC (STROBE_CYC),
  .HOLD_CYC   (HOLD_CYC),
  .GAP_CYC    (GAP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .req_ready (req_ready),
  .done      (done),
  .bus_a0    (bus_a0),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_oe    (bus_oe),
  .bus_dout  (bus_dout)
);

// File: tb/tb_pbus_master.sv
`timescale 1ns/1ps
module tb_pbus_master;
  localparam int CLK_PS   = 4000;
  localparam int MAXB     = 8;
  localparam int WATCHDOG = 190000;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_STROBE = cyc_of(40);
  localparam int E_HOLD   = cyc_of(40);
  localparam int E_GAP    = cyc_of(1000);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_cmd;
  logic        req_rd;
  logic [3:0]  req_len;
  logic [63:0] req_wdata;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        done;
  logic        bus_a0, bus_rd_n, bus_wr_n, bus_oe;
  logic [7:0]  bus_dout;
  logic [7:0]  bus_din;
  logic        intr_n;
  logic        irq;

  always #2 clk = ~clk;

  pbus_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_rd(req_rd), .req_len(req_len), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .bus_a0(bus_a0),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_oe(bus_oe), .bus_dout(bus_dout),
    .bus_din(bus_din), .intr_n(intr_n), .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // Bus model and access log
  logic       acc_a0 [0:15];
  logic       acc_wr [0:15];
  logic [7:0] acc_byte [0:15];
  logic [7:0] exp_rd [0:15];
  logic [7:0] got_rd [0:15];
  int n_acc, n_exp, n_got, done_cnt;
  int low_run, quiet_run, hold_run;
  logic prev_strobe, prev_quiet, prev_oe;
  logic [7:0] cur_rd;

  always @(negedge clk) begin
    logic strobe_any, quiet;
    strobe_any = !bus_rd_n || !bus_wr_n;
    quiet      = bus_rd_n && bus_wr_n && !bus_oe;
    if (rst_n) begin
      if (prev_quiet && !quiet)
        chk(quiet_run >= E_GAP, "R7 recovery gap", quiet_run, E_GAP);
      if (strobe_any && !prev_strobe) begin
        chk(!(!bus_rd_n && !bus_wr_n), "R12 strobe overlap", {bus_rd_n, bus_wr_n}, 2'b11);
        if (n_acc < 16) begin
          acc_a0[n_acc]   = bus_a0;
          acc_wr[n_acc]   = !bus_wr_n;
          acc_byte[n_acc] = bus_dout;
        end
        if (!bus_wr_n)
          chk(prev_oe && bus_oe, "R3 driver enabled before strobe", {prev_oe, bus_oe}, 2'b11);
        if (!bus_rd_n) begin
          chk(!bus_oe, "R6 bus released on read", bus_oe, 0);
          cur_rd = 8'($urandom);
          if (n_exp < 16) exp_rd[n_exp] = cur_rd;
          n_exp++;
        end
        n_acc++;
      end
      if (!strobe_any && prev_strobe)
        chk(low_run >= E_STROBE, "R4 strobe width", low_run, E_STROBE);
      if (prev_oe && !bus_oe)
        chk(hold_run >= E_HOLD, "R5 write hold", hold_run, E_HOLD);
      if (rd_valid) begin
        if (n_got < 16) got_rd[n_got] = rd_data;
        n_got++;
      end
      if (done) done_cnt++;
    end
    bus_din   = (!bus_rd_n) ? cur_rd : ~cur_rd;
    low_run   = strobe_any ? low_run + 1 : 0;
    quiet_run = quiet ? quiet_run + 1 : 0;
    hold_run  = (bus_oe && bus_wr_n) ? hold_run + 1 : 0;
    prev_strobe = strobe_any;
    prev_quiet  = quiet;
    prev_oe     = bus_oe;
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic clear_log();
    n_acc = 0; n_exp = 0; n_got = 0; done_cnt = 0;
  endtask

  task automatic start_txn(input logic [7:0] cmd, input logic rd, input logic [3:0] len,
                           input logic [63:0] wd);
    clear_log();
    @(negedge clk);
    chk(req_ready, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_cmd = cmd; req_rd = rd; req_len = len; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_cmd = ~cmd;
    req_wdata = ~wd;
  endtask

  task automatic finish_txn(input logic [7:0] cmd, input logic rd, input logic [3:0] len,
                            input logic [63:0] wd);
    int eff;
    bit ok;
    eff = (len > MAXB) ? MAXB : int'(len);
    while (done_cnt == 0) @(negedge clk);
    chk(req_ready, "R9 ready with done", req_ready, 1);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    chk(n_acc == eff + 1, "R8 access count", n_acc, eff + 1);
    chk(acc_a0[0] && acc_wr[0] && acc_byte[0] == cmd, "R2 command phase",
        {acc_a0[0], acc_wr[0], acc_byte[0]}, {2'b11, cmd});
    ok = 1;
    for (int i = 1; i <= eff && i < 16; i++) begin
      if (acc_a0[i] !== 1'b0 || acc_wr[i] !== !rd) ok = 0;
      if (!rd && acc_byte[i] !== wd[8*(i-1) +: 8]) begin
        ok = 0;
        $display("  byte %0d act=%0h exp=%0h", i, acc_byte[i], wd[8*(i-1) +: 8]);
      end
    end
    chk(ok, rd ? "R2 data phase reads" : "R8 data phase write bytes", ok, 1);
    if (rd) begin
      ok = (n_got == eff);
      for (int i = 0; i < eff && i < 16; i++)
        if (got_rd[i] !== exp_rd[i]) ok = 0;
      chk(ok, "R6 read bytes returned in order", n_got, eff);
    end else begin
      chk(n_got == 0, "R6 no read strobe on write", n_got, 0);
    end
  endtask

  task automatic run_txn(input logic [7:0] cmd, input logic rd, input logic [3:0] len,
                         input logic [63:0] wd);
    start_txn(cmd, rd, len, wd);
    finish_txn(cmd, rd, len, wd);
  endtask

  initial begin
    bit busy_ok;
    void'($urandom(32'd20071023));
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_rd = 1'b0; req_len = '0;
    req_wdata = '0; intr_n = 1'b1; bus_din = '0; cur_rd = 8'h5a;
    n_acc = 0; n_exp = 0; n_got = 0; done_cnt = 0;
    low_run = 0; quiet_run = 0; hold_run = 0;
    prev_strobe = 0; prev_quiet = 1; prev_oe = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(req_ready && bus_rd_n && bus_wr_n && !bus_oe && !rd_valid && !done && !irq,
        "R1 reset state", {req_ready, bus_rd_n, bus_wr_n, bus_oe, rd_valid, done, irq},
        7'b1110000);

    // R11 interrupt synchroniser latency
    intr_n = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R11 irq after one edge", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R11 irq after two edges", irq, 1);
    intr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R11 irq release", irq, 0);

    // Directed corner cases
    run_txn(8'hfd, 1'b1, 4'd2, 64'h0);                      // R6 two-byte read
    run_txn(8'hfb, 1'b0, 4'd1, 64'h0000_0000_0000_00c0);    // R8 one-byte write
    run_txn(8'hf2, 1'b0, 4'd0, 64'h0);                      // R8 command only
    run_txn(8'h3c, 1'b0, 4'd12, 64'h8877_6655_4433_2211);   // R8 length clamp
    run_txn(8'hf4, 1'b1, 4'd8, 64'h0);                      // R6 full read burst

    // R10 request during a busy transaction
    start_txn(8'hd0, 1'b0, 4'd2, 64'h0000_0000_0000_a5c3);
    repeat (300) @(negedge clk);
    req_valid = 1'b1; req_cmd = 8'h99; req_rd = 1'b1; req_len = 4'd5;
    busy_ok = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (req_ready) busy_ok = 0;
    end
    req_valid = 1'b0;
    chk(busy_ok, "R10 ready low while busy", busy_ok, 1);
    finish_txn(8'hd0, 1'b0, 4'd2, 64'h0000_0000_0000_a5c3);
    repeat (E_GAP + 50) @(negedge clk);
    chk(n_acc == 3, "R10 busy request ignored", n_acc, 3);

    // Constrained random transactions
    for (int t = 0; t < 24; t++) begin
      logic [7:0]  c;
      logic        r;
      logic [3:0]  l;
      logic [63:0] w;
      c = 8'($urandom);
      r = 1'($urandom);
      l = 4'($urandom_range(0, 9));
      w = {$urandom, $urandom};
      run_txn(c, r, l, w);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule